// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side and uses a third table to choose between them. The first predictor works per branch. It keeps a shift register of each branch's own recent outcomes and uses that pattern to select a 3-bit saturating counter. The second predictor works on the whole program. It keeps one shared 12-bit history of recent directions and uses it to select a 2-bit counter. A table of 2-bit choice counters, indexed by that same shared history, learns which of the two predictors to trust for the current path.

The fetch stage asks for a direction through the predict port. It receives the guess together with a copy of the shared history as it stood before the guess. In the same clock edge, the guess is shifted into the shared history, so the history runs ahead of resolution. When the branch resolves, the back end sends the branch address, the real outcome, a mispredict flag and the saved copy through the update port. The saved copy selects the global and choice counters to train. On a mispredict, the shared history is rebuilt from the saved copy with the real outcome appended.

Top module: `bp_tournament`

## Requirements
- R1: After reset, the shared history is zero, every prediction is not-taken and the returned checkpoint is zero. Reset values are: per-branch histories 0, 3-bit counters 3, 2-bit global counters 1, choice counters 1.
- R2: `pred_ckpt` always shows the current shared history. On a clock edge with `pred_valid` high and no mispredict update, the history shifts left by one bit and `pred_taken` enters bit 0.
- R3: On a clock edge with `upd_valid` and `upd_mispredict` high, the shared history becomes `{upd_ckpt[10:0], upd_taken}`.
- R4: The per-branch history table has 1024 entries of 10 bits, selected by `pc[11:2]`. Other PC bits are ignored. An update shifts the actual outcome into bit 0 of the entry. The entry's old value selects one of 1024 saturating 3-bit counters, and that counter predicts taken when it is 4 or more.
- R5: There are 4096 saturating 2-bit global counters, and each predicts taken when it is 2 or more. A prediction reads the counter selected by the live shared history. An update trains the counter selected by `upd_ckpt`.
- R6: There are 4096 saturating 2-bit choice counters. A choice value of 2 or more selects the global prediction, and a lower value selects the local one. A choice counter is trained only when the local and global predictions disagree at update time, and it moves toward the one that matched the outcome.
- R7: When a mispredict update and a valid prediction fall on the same edge, the restore from R3 wins.
- R8: With `pred_valid` low and no mispredict update, the shared history keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A prediction is consumed this cycle |
| pred_pc | input | 32 | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_ckpt | output | 12 | Shared history before this prediction |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_mispredict | input | 1 | The earlier prediction was wrong |
| upd_ckpt | input | 12 | Checkpoint returned with the prediction |

## Verification
A wrong counter or choice entry stays hidden until the bench asks for a prediction that reads it. After that it changes `pred_taken` in the same cycle, so the bench compares the output against an independent model on every cycle. A corrupted shared history is different: it shows on `pred_ckpt` one edge after the push or restore that caused it, and every later global lookup reads the wrong entries. Hand-worked vectors cover the choice switching over, address aliasing and the restore priority. A long mixed stream drives counters and histories into saturation.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTR_W = 4;

  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] v,
                                                input logic up, input int unsigned w);
    logic [CTR_W-1:0] top;
    top = CTR_W'((1 << w) - 1);
    if (up) return (v == top) ? v : v + 4'd1;
    else    return (v == '0)  ? v : v - 4'd1;
  endfunction

  function automatic logic ctr_dir(input logic [CTR_W-1:0] v, input int unsigned w);
    return v[w-1];
  endfunction
endpackage

// File: rtl/bp_local.sv
module bp_local
  import bp_pkg::*;
#(
  parameter int PCW = 32,
  parameter int LHI = 10,
  parameter int LHW = 10,
  parameter int LCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PCW-1:0] rd_pc,
  output logic           rd_dir,
  input  logic           up_en,
  input  logic [PCW-1:0] up_pc,
  input  logic           up_taken,
  output logic           up_dir
);
  localparam int LH_N = 1 << LHI;
  localparam int LC_N = 1 << LHW;
  localparam logic [LCW-1:0] LC_INIT = LCW'((1 << (LCW-1)) - 1);

  logic [LHW-1:0] lh_tab [LH_N];
  logic [LCW-1:0] lc_tab [LC_N];

  logic [LHI-1:0]   rd_li, up_li;
  logic [LHW-1:0]   rd_hist, up_hist, up_hist_new;
  logic [LCW-1:0]   rd_cnt, up_cnt_old, up_cnt_new;
  logic [CTR_W-1:0] up_step_w;

  assign rd_li   = rd_pc[LHI+1:2];
  assign up_li   = up_pc[LHI+1:2];
  assign rd_hist = lh_tab[rd_li];
  assign rd_cnt  = lc_tab[rd_hist];
  assign rd_dir  = ctr_dir({{(CTR_W-LCW){1'b0}}, rd_cnt}, LCW);

  assign up_hist     = lh_tab[up_li];
  assign up_cnt_old  = lc_tab[up_hist];
  assign up_dir      = ctr_dir({{(CTR_W-LCW){1'b0}}, up_cnt_old}, LCW);
  assign up_step_w   = ctr_step({{(CTR_W-LCW){1'b0}}, up_cnt_old}, up_taken, LCW);
  assign up_cnt_new  = up_step_w[LCW-1:0];
  assign up_hist_new = {up_hist[LHW-2:0], up_taken};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LH_N; i++) lh_tab[i] <= '0;
      for (int j = 0; j < LC_N; j++) lc_tab[j] <= LC_INIT;
    end else if (up_en) begin
      lh_tab[up_li]   <= up_hist_new;
      lc_tab[up_hist] <= up_cnt_new;
    end
  end

  always_comb begin
    if (rst_n && up_en) begin
      AST_LCNT_SAT: assert (up_cnt_new != up_cnt_old ||
                            (up_taken ? (up_cnt_old == '1) : (up_cnt_old == '0)))
        else $error("local counter stuck below limit"); // R4
      AST_LCNT_DIR: assert (up_taken ? (up_cnt_new >= up_cnt_old) : (up_cnt_new <= up_cnt_old))
        else $error("local counter moved against outcome"); // R4
    end
  end

  logic unused_bits;
  assign unused_bits = ^{rd_pc[PCW-1:LHI+2], rd_pc[1:0], up_pc[PCW-1:LHI+2], up_pc[1:0],
                         up_step_w[CTR_W-1:LCW]};
endmodule

// File: rtl/bp_global.sv
module bp_global
  import bp_pkg::*;
#(
  parameter int GHW = 12,
  parameter int GCW = 2,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [GHW-1:0] rd_hist,
  output logic           rd_gdir,
  output logic           rd_use_g,
  input  logic           up_en,
  input  logic [GHW-1:0] up_hist,
  input  logic           up_taken,
  input  logic           up_ldir
);
  localparam int G_N = 1 << GHW;
  localparam logic [GCW-1:0] GC_INIT = GCW'((1 << (GCW-1)) - 1);
  localparam logic [CHW-1:0] CH_INIT = CHW'((1 << (CHW-1)) - 1);

  logic [GCW-1:0] gc_tab [G_N];
  logic [CHW-1:0] ch_tab [G_N];

  logic [GCW-1:0]   gc_rd, gc_old, gc_new;
  logic [CHW-1:0]   ch_rd, ch_old, ch_new;
  logic [CTR_W-1:0] gc_step_w, ch_step_w;
  logic             up_gdir, disagree, g_right;

  assign gc_rd    = gc_tab[rd_hist];
  assign ch_rd    = ch_tab[rd_hist];
  assign rd_gdir  = ctr_dir({{(CTR_W-GCW){1'b0}}, gc_rd}, GCW);
  assign rd_use_g = ctr_dir({{(CTR_W-CHW){1'b0}}, ch_rd}, CHW);

  assign gc_old    = gc_tab[up_hist];
  assign ch_old    = ch_tab[up_hist];
  assign up_gdir   = ctr_dir({{(CTR_W-GCW){1'b0}}, gc_old}, GCW);
  assign gc_step_w = ctr_step({{(CTR_W-GCW){1'b0}}, gc_old}, up_taken, GCW);
  assign gc_new    = gc_step_w[GCW-1:0];
  assign disagree  = up_gdir ^ up_ldir;
  assign g_right   = (up_gdir == up_taken);
  assign ch_step_w = ctr_step({{(CTR_W-CHW){1'b0}}, ch_old}, g_right, CHW);
  assign ch_new    = disagree ? ch_step_w[CHW-1:0] : ch_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < G_N; i++) begin
        gc_tab[i] <= GC_INIT;
        ch_tab[i] <= CH_INIT;
      end
    end else if (up_en) begin
      gc_tab[up_hist] <= gc_new;
      ch_tab[up_hist] <= ch_new;
    end
  end

  always_comb begin
    if (rst_n && up_en) begin
      AST_GCNT_SAT: assert (up_taken ? (gc_new >= gc_old) : (gc_new <= gc_old))
        else $error("global counter wrapped"); // R5
      AST_CHOICE_TOWARD: assert (!disagree || (g_right ? ch_new >= ch_old : ch_new <= ch_old))
        else $error("choice moved away from the correct side"); // R6
    end
  end

  logic unused_bits;
  assign unused_bits = ^{gc_step_w[CTR_W-1:GCW], ch_step_w[CTR_W-1:CHW]};
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int GHW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spec_en,
  input  logic           spec_bit,
  input  logic           fix_en,
  input  logic [GHW-1:0] fix_ckpt,
  input  logic           fix_bit,
  output logic [GHW-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)       hist <= '0;
    else if (fix_en)  hist <= {fix_ckpt[GHW-2:0], fix_bit};
    else if (spec_en) hist <= {hist[GHW-2:0], spec_bit};
  end

  AST_GHR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (hist == {$past(fix_ckpt[GHW-2:0]), $past(fix_bit)})); // R3
  AST_GHR_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_en && !fix_en) |=> (hist == {$past(hist[GHW-2:0]), $past(spec_bit)})); // R2
  AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_en && !fix_en) |=> $stable(hist)); // R8

  logic unused_top;
  assign unused_top = fix_ckpt[GHW-1];
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament #(
  parameter int PCW = 32,
  parameter int LHI = 10,
  parameter int LHW = 10,
  parameter int LCW = 3,
  parameter int GHW = 12,
  parameter int GCW = 2,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pred_valid,
  input  logic [PCW-1:0] pred_pc,
  output logic           pred_taken,
  output logic [GHW-1:0] pred_ckpt,
  input  logic           upd_valid,
  input  logic [PCW-1:0] upd_pc,
  input  logic           upd_taken,
  input  logic           upd_mispredict,
  input  logic [GHW-1:0] upd_ckpt
);
  logic [GHW-1:0] ghist;
  logic           l_dir, g_dir, use_g, up_l_dir;
  logic           ev_restore, ev_push;

  assign ev_restore = upd_valid & upd_mispredict;
  assign ev_push    = pred_valid & ~ev_restore;

  bp_local #(.PCW(PCW), .LHI(LHI), .LHW(LHW), .LCW(LCW)) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(pred_pc), .rd_dir(l_dir),
    .up_en(upd_valid), .up_pc(upd_pc), .up_taken(upd_taken), .up_dir(up_l_dir)
  );

  bp_global #(.GHW(GHW), .GCW(GCW), .CHW(CHW)) u_global (
    .clk(clk), .rst_n(rst_n),
    .rd_hist(ghist), .rd_gdir(g_dir), .rd_use_g(use_g),
    .up_en(upd_valid), .up_hist(upd_ckpt), .up_taken(upd_taken), .up_ldir(up_l_dir)
  );

  bp_ghr #(.GHW(GHW)) u_ghr (
    .clk(clk), .rst_n(rst_n),
    .spec_en(pred_valid), .spec_bit(pred_taken),
    .fix_en(ev_restore), .fix_ckpt(upd_ckpt), .fix_bit(upd_taken),
    .hist(ghist)
  );

  assign pred_taken = use_g ? g_dir : l_dir;
  assign pred_ckpt  = ghist;

  AST_PUSH_TRACKS_CKPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (pred_ckpt[GHW-1:1] == $past(pred_ckpt[GHW-2:0]))); // R2
  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_restore && pred_valid) |=> (pred_ckpt[0] == $past(upd_taken))); // R7
endmodule

// File: tb/sim_bp_tournament.sv
module sim_bp_tournament;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_valid = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic [11:0] pred_ckpt;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        upd_mispredict = 1'b0;
  logic [11:0] upd_ckpt = '0;

  always #5 clk = ~clk;

  bp_tournament u0 (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_ckpt(pred_ckpt),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .upd_ckpt(upd_ckpt)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // independent reference state
  int m_lh [1024];
  int m_lc [1024];
  int m_gc [4096];
  int m_ch [4096];
  int m_g;

  task automatic model_reset();
    foreach (m_lh[i]) begin m_lh[i] = 0; m_lc[i] = 3; end
    foreach (m_gc[i]) begin m_gc[i] = 1; m_ch[i] = 1; end
    m_g = 0;
  endtask

  function automatic int model_pred(input int pc);
    int h;
    h = m_lh[(pc >> 2) % 1024];
    if (m_ch[m_g] > 1) return (m_gc[m_g] > 1) ? 1 : 0;
    return (m_lc[h] > 3) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        pv;
    logic [15:0] ppc;
    logic        uv;
    logic [15:0] upc;
    logic        ut;
    logic        um;
    logic [11:0] uck;
    logic        ep;
    logic [11:0] eck;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b0, 12'h000}, // R1 fresh state
    '{1'b0, 16'h0100, 1'b1, 16'h0100, 1'b1, 1'b0, 12'h000, 1'b0, 12'h000}, // R4 train
    '{1'b0, 16'h1102, 1'b1, 16'h0100, 1'b1, 1'b0, 12'h000, 1'b0, 12'h000}, // R6 local chosen, R4 alias
    '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b1, 12'h000}, // R6 global chosen, R5
    '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b0, 12'h001}, // R2 taken pushed
    '{1'b0, 16'h0100, 1'b1, 16'h0100, 1'b1, 1'b1, 12'h001, 1'b0, 12'h002}, // R2 not-taken pushed
    '{1'b0, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b0, 12'h003}, // R3 restore
    '{1'b0, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b0, 12'h003}, // R8 hold
    '{1'b1, 16'h0100, 1'b1, 16'h0100, 1'b0, 1'b1, 12'h005, 1'b0, 12'h003}, // R7 both events
    '{1'b0, 16'h0104, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b1, 12'h00A}, // R7 result, R4 other entry
    '{1'b0, 16'h1101, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1'b0, 12'h00A}  // R4 alias of 0x100
  };

  task automatic step(input bit pv, input int ppc, input bit uv, input int upc,
                      input bit ut, input bit um, input int uck,
                      output bit got_p, output int got_ck);
    int ep, li, h, lp, gp;
    @(negedge clk);
    pred_valid = pv; pred_pc = 32'(ppc);
    upd_valid = uv; upd_pc = 32'(upc); upd_taken = ut; upd_mispredict = um; upd_ckpt = 12'(uck);
    #2;
    got_p = pred_taken;
    got_ck = int'(pred_ckpt);
    ep = model_pred(ppc);
    check(got_p == ep[0], "R4/R5/R6 model direction", int'(got_p), ep);
    check(got_ck == m_g, "R2/R3 model checkpoint", got_ck, m_g);
    if (uv) begin
      li = (upc >> 2) % 1024;
      h = m_lh[li];
      lp = (m_lc[h] >= 4) ? 1 : 0;
      gp = (m_gc[uck] >= 2) ? 1 : 0;
      if (lp != gp) begin
        if (gp == int'(ut)) m_ch[uck] = (m_ch[uck] == 3) ? 3 : m_ch[uck] + 1;
        else                m_ch[uck] = (m_ch[uck] == 0) ? 0 : m_ch[uck] - 1;
      end
      if (ut) begin
        if (m_lc[h] < 7) m_lc[h]++;
        if (m_gc[uck] < 3) m_gc[uck]++;
      end else begin
        if (m_lc[h] > 0) m_lc[h]--;
        if (m_gc[uck] > 0) m_gc[uck]--;
      end
      m_lh[li] = ((h * 2) + int'(ut)) % 1024;
    end
    if (uv && um)  m_g = ((uck * 2) + int'(ut)) % 4096;
    else if (pv)   m_g = ((m_g * 2) + ep) % 4096;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit p;
    int ck;
    logic [15:0] r;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(TBL[k].pv, int'(TBL[k].ppc), TBL[k].uv, int'(TBL[k].upc), TBL[k].ut,
           TBL[k].um, int'(TBL[k].uck), p, ck);
      check(p == TBL[k].ep, $sformatf("vector %0d direction", k), int'(p), int'(TBL[k].ep));
      check(ck == int'(TBL[k].eck), $sformatf("vector %0d checkpoint", k), ck, int'(TBL[k].eck));
    end

    // mixed stream: biased branches saturate counters and histories (R4 R5 R6), restores (R3 R7)
    r = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      int sel, pc, uck;
      bit t;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      sel = int'(r[1:0]);
      pc = (sel == 0) ? 32'h40 : (sel == 1) ? 32'h44 : (sel == 2) ? 32'h1040 : 32'h48;
      t = (sel == 0 || sel == 2) ? (r[7:5] != 3'd0) : (sel == 1) ? (r[7:5] == 3'd0) : r[8];
      uck = r[9] ? int'(pred_ckpt) : int'({r[15:12], r[7:0]});
      step(r[10], pc, r[11], pc, t, r[11] && (r[14:12] == 3'd0), uck, p, ck);
    end

    // R1: reset mid-run returns all state to its initial values
    @(negedge clk);
    rst_n = 1'b0; pred_valid = 1'b0; upd_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    pred_pc = 32'h40;
    #2;
    check(pred_taken == 1'b0, "R1 direction after reset", int'(pred_taken), 0);
    check(pred_ckpt == 12'h000, "R1 checkpoint after reset", int'(pred_ckpt), 0);
    step(1'b1, 32'h44, 1'b0, 0, 1'b0, 1'b0, 0, p, ck);
    check(p == 1'b0, "R1 second branch after reset", int'(p), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule